// File: doc/BRIEF.md
# Serialized Interrupt Peripheral Agent

This block is the peripheral end of a single-wire, clock-synchronous serialized interrupt bus. A cycle opens with a Start pulse, a low stretch of one or more clocks. After it come a fixed number of three-clock interrupt frames and a closing Stop pulse. The agent counts frames from the end of each Start pulse. When its assigned frame comes round, it reports its local interrupt level on the line.

The agent measures the low width of every Stop pulse to learn the bus mode for the next cycle. In Continuous mode only the host opens cycles. In Quiet mode the agent may open a cycle itself when it has a new interrupt level to report. The line is presented as an output enable and an output value, with the resolved line level sampled back. All driving and sampling happens on the rising clock edge.

Top module: `sirq_agent`

## Requirements
- R1: While reset is asserted, and after it is released, the output enable is low. The mode after reset is Continuous, so no Start is driven until a 2-clock Stop has been seen.
- R2: Let the Stop pulse be the low run that begins after the last frame. A run of exactly 2 low clocks selects Quiet mode and a run of exactly 3 selects Continuous mode. The new mode applies from the clock in which the line is seen high again.
- R3: Let clock s be the last low clock of a Stop pulse, and clock s+1 the high clock that ends it. A Start driven by the agent falls no earlier than clock s+3.
- R4: In Continuous mode the agent never drives a Start, even with an unreported interrupt change.
- R5: Number the first low clock of a Start pulse of length L as clock 0. Clock L is the recovery clock and clock L+1 is the turnaround. Frame k occupies clocks L+2+3k (sample), L+3+3k (recovery) and L+4+3k (turnaround). In the sample clock of its own frame the agent drives 0 when its registered interrupt is 1, and otherwise leaves the line undriven. It drives 1 in the recovery clock and nothing in the turnaround clock. Outside its own frame it does not drive.
- R6: A Start opened by the agent is exactly one driven-low clock. The output enable is low in the next clock.
- R7: In Quiet mode and while idle, the agent opens a cycle only when its registered interrupt level differs from the level it reported in its last own sample clock. The interrupt input is registered once, so a change on it produces a Start two clocks later at the earliest.
- R8: A Stop pulse whose low width is neither 2 nor 3 clocks leaves the mode unchanged. Widths beyond the counter range saturate and count as invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all activity on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sirq_in | input | 1 | Sampled level of the resolved serial line |
| irq_lvl | input | 1 | Local interrupt level, 1 = active |
| slot_sel | input | SLOT_W | Index of the frame this agent owns |
| sirq_oe | output | 1 | Line output enable |
| sirq_out | output | 1 | Line drive value when enabled |

## Verification
The bench builds the agent with NUM_FRAMES = 5. This keeps cycles short enough to sweep every owned frame index, each with the interrupt low and high, under Start lengths from one to six clocks. The bench checks the drive in every clock of those cycles against the frame arithmetic. With that small frame count it can also chain cycles that close with Stop widths of 1, 2, 3 and 4. It then watches the idle clocks after each one to see whether a self-started cycle appears, and in which clock.

// File: rtl/sirq_agent_pkg.sv
package sirq_agent_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SELF,
    PH_START,
    PH_START_TA,
    PH_FRAME,
    PH_STOP_WAIT,
    PH_STOP_LOW
  } phase_e;

  typedef enum logic {
    MODE_CONT  = 1'b0,
    MODE_QUIET = 1'b1
  } mode_e;

  localparam logic [1:0] SUB_SAMPLE = 2'd0;
  localparam logic [1:0] SUB_RECOV  = 2'd1;
  localparam logic [1:0] SUB_TURN   = 2'd2;

  localparam int unsigned QUIET_WIDTH = 2;
  localparam int unsigned CONT_WIDTH  = 3;

  // Mode chosen by a completed Stop pulse of the given low width.
  function automatic mode_e next_mode(input int unsigned width, input mode_e cur);
    if (width == QUIET_WIDTH)     return MODE_QUIET;
    else if (width == CONT_WIDTH) return MODE_CONT;
    else                          return cur;
  endfunction

  // True when a low width is one of the two meaningful Stop widths.
  function automatic logic width_is_valid(input int unsigned width);
    return (width == QUIET_WIDTH) || (width == CONT_WIDTH);
  endfunction

endpackage

// File: rtl/sirq_frame_seq.sv
module sirq_frame_seq
  import sirq_agent_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 17,
  parameter int unsigned SLOT_W     = 5,
  parameter int unsigned CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              self_go,
  output phase_e            phase,
  output logic [SLOT_W-1:0] frame_idx,
  output logic [1:0]        sub,
  output logic              stop_done,
  output logic [CNT_W-1:0]  stop_width
);

  localparam logic [SLOT_W-1:0] LAST_FRAME = SLOT_W'(NUM_FRAMES - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX    = {CNT_W{1'b1}};

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      frame_idx <= '0;
      sub       <= SUB_SAMPLE;
      low_cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (!line_in)     phase <= PH_START;
          else if (self_go) phase <= PH_SELF;
        end
        PH_SELF: begin
          phase <= line_in ? PH_IDLE : PH_START;
        end
        PH_START: begin
          if (line_in) phase <= PH_START_TA;
        end
        PH_START_TA: begin
          phase     <= PH_FRAME;
          frame_idx <= '0;
          sub       <= SUB_SAMPLE;
        end
        PH_FRAME: begin
          if (sub == SUB_TURN) begin
            sub <= SUB_SAMPLE;
            if (frame_idx == LAST_FRAME) phase <= PH_STOP_WAIT;
            else                         frame_idx <= frame_idx + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
        PH_STOP_WAIT: begin
          if (!line_in) begin
            phase   <= PH_STOP_LOW;
            low_cnt <= CNT_W'(1);
          end
        end
        PH_STOP_LOW: begin
          if (line_in)                phase   <= PH_IDLE;
          else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign stop_done  = (phase == PH_STOP_LOW) && line_in;
  assign stop_width = low_cnt;

  // A self-driven Start needs the recovery clock and one more idle high clock before it.
  AST_SELF_GAP: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_SELF) |-> ($past(line_in) && $past(line_in, 2))); // R3

endmodule

// File: rtl/sirq_mode_track.sv
module sirq_mode_track
  import sirq_agent_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_done,
  input  logic [CNT_W-1:0] stop_width,
  output mode_e            mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode <= MODE_CONT;
    else if (stop_done) mode <= next_mode(int'(stop_width), mode);
  end

  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (stop_done && stop_width == CNT_W'(2)) |=> (mode == MODE_QUIET)); // R2
  AST_MODE_CONT: assert property (@(posedge clk) disable iff (!rst_n) (stop_done && stop_width == CNT_W'(3)) |=> (mode == MODE_CONT)); // R2
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (!stop_done || !width_is_valid(int'(stop_width))) |=> $stable(mode)); // R8

endmodule

// File: rtl/sirq_slot_drive.sv
module sirq_slot_drive
  import sirq_agent_pkg::*;
#(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [SLOT_W-1:0] frame_idx,
  input  logic [1:0]        sub,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              irq_lvl,
  input  mode_e             mode,
  output logic              self_go,
  output logic              bus_oe,
  output logic              bus_out
);

  logic irq_q;
  logic last_rep;
  logic own_slot;
  logic sample_evt;
  logic recov_evt;
  logic pending;

  assign own_slot   = (phase == PH_FRAME) && (frame_idx == slot_sel);
  assign sample_evt = own_slot && (sub == SUB_SAMPLE);
  assign recov_evt  = own_slot && (sub == SUB_RECOV);
  assign pending    = irq_q != last_rep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      last_rep <= 1'b0;
    end else begin
      irq_q <= irq_lvl;
      if (sample_evt) last_rep <= irq_q;
    end
  end

  assign self_go = (phase == PH_IDLE) && (mode == MODE_QUIET) && pending;
  assign bus_oe  = (phase == PH_SELF) || (sample_evt && irq_q) || recov_evt;
  assign bus_out = recov_evt;

  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!bus_oe); // R1
  end

  AST_NO_START_CONT: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_SELF) |-> (mode == MODE_QUIET)); // R4
  AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_SELF) |=> !bus_oe); // R6
  AST_OWN_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (bus_oe && phase != PH_SELF) |-> (phase == PH_FRAME && frame_idx == slot_sel && sub != SUB_TURN)); // R5
  AST_START_NEEDS_NEWS: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_SELF) |-> $past(irq_q != last_rep)); // R7

endmodule

// File: rtl/sirq_agent.sv
module sirq_agent
  import sirq_agent_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 17,
  parameter int unsigned STOP_CNT_W = 3,
  localparam int unsigned SLOT_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sirq_in,
  input  logic              irq_lvl,
  input  logic [SLOT_W-1:0] slot_sel,
  output logic              sirq_oe,
  output logic              sirq_out
);

  phase_e                phase;
  logic [SLOT_W-1:0]     frame_idx;
  logic [1:0]            sub;
  logic                  stop_done;
  logic [STOP_CNT_W-1:0] stop_width;
  logic                  self_go;
  mode_e                 mode;

  sirq_frame_seq #(
    .NUM_FRAMES (NUM_FRAMES),
    .SLOT_W     (SLOT_W),
    .CNT_W      (STOP_CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (sirq_in),
    .self_go    (self_go),
    .phase      (phase),
    .frame_idx  (frame_idx),
    .sub        (sub),
    .stop_done  (stop_done),
    .stop_width (stop_width)
  );

  sirq_mode_track #(
    .CNT_W (STOP_CNT_W)
  ) u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_done  (stop_done),
    .stop_width (stop_width),
    .mode       (mode)
  );

  sirq_slot_drive #(
    .SLOT_W (SLOT_W)
  ) u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .frame_idx (frame_idx),
    .sub       (sub),
    .slot_sel  (slot_sel),
    .irq_lvl   (irq_lvl),
    .mode      (mode),
    .self_go   (self_go),
    .bus_oe    (sirq_oe),
    .bus_out   (sirq_out)
  );

endmodule

// File: tb/tb_sirq_agent.sv
module tb_sirq_agent;

  localparam int NF = 5;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          irq;
  logic [SW-1:0] slot;
  logic          host_oe;
  logic          host_val;
  logic          dut_oe;
  logic          dut_out;
  logic          line;

  int  errs   = 0;
  int  checks = 0;
  bit  done   = 1'b0;
  bit  last_rep_m = 1'b0;

  always #4 clk = ~clk;

  assign line = (dut_oe ? dut_out : 1'b1) & (host_oe ? host_val : 1'b1);

  sirq_agent #(.NUM_FRAMES(NF), .STOP_CNT_W(3)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sirq_in  (line),
    .irq_lvl  (irq),
    .slot_sel (slot),
    .sirq_oe  (dut_oe),
    .sirq_out (dut_out)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Expected {oe, value} of the agent in clock i of a cycle with Start length L.
  function automatic bit [1:0] exp_drv(input int i, input int L, input int s, input bit v);
    int base = L + 2;
    if (i >= base && i < base + 3 * NF) begin
      int f = (i - base) / 3;
      int p = (i - base) % 3;
      if (f == s) begin
        if (p == 0) return {v, 1'b0};
        if (p == 1) return 2'b11;
      end
    end
    return 2'b00;
  endfunction

  // Host side of one cycle; flip toggles irq in the first Stop clock.
  task automatic run_cycle(input int L, input int stoplen, input bit dut_first, input bit flip, input string req);
    int S = L + 2 + 3 * NF;
    bit v = irq;
    for (int i = (dut_first ? 1 : 0); i <= S + stoplen; i++) begin
      bit [1:0] e;
      @(negedge clk);
      e = exp_drv(i, L, int'(slot), v);
      chk(dut_oe == e[1], req, "oe", int'(dut_oe), int'(e[1]));
      if (e[1]) chk(dut_out == e[0], req, "drive value", int'(dut_out), int'(e[0]));
      if (i < L)                              begin host_oe = 1'b1; host_val = 1'b0; end
      else if (i == L)                        begin host_oe = 1'b1; host_val = 1'b1; end
      else if (i >= S && i < S + stoplen)     begin host_oe = 1'b1; host_val = 1'b0; end
      else if (i == S + stoplen)              begin host_oe = 1'b1; host_val = 1'b1; end
      else                                    host_oe = 1'b0;
      if (flip && i == S) irq = ~irq;
    end
    last_rep_m = v;
  endtask

  // Idle clocks after a Stop (j=0 is the clock after the recovery high); start_at<0: no Start expected.
  task automatic idle_watch(input int n, input int start_at, input string req);
    for (int j = 0; j < n; j++) begin
      bit e;
      @(negedge clk);
      host_oe = 1'b0;
      e = (j == start_at);
      chk(dut_oe == e, req, "self start oe", int'(dut_oe), int'(e));
      if (e) begin
        chk(dut_out == 1'b0, req, "self start level", int'(dut_out), 0);
        host_oe  = 1'b1;
        host_val = 1'b0;
        break;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; irq = 1'b0; slot = '0; host_oe = 1'b0; host_val = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dut_oe == 1'b0, "R1", "oe in reset", int'(dut_oe), 0);
    end
    rst_n = 1'b1;
    irq = 1'b1;
    // Continuous after reset: an unreported change must not open a cycle (R1)
    idle_watch(8, -1, "R1");

    // Frame position sweep in Continuous mode (R5), then unreported change stays silent (R4)
    for (int s = 0; s < NF; s++) begin
      for (int v = 0; v < 2; v++) begin
        @(negedge clk);
        host_oe = 1'b0;
        slot = SW'(s);
        irq = v[0];
        run_cycle(1 + (s * 2 + v) % 6, 3, 1'b0, 1'b0, "R5");
        irq = ~irq;
        idle_watch(4, -1, "R4");
      end
    end

    // Enter Quiet with nothing new to report: stays idle (R2 width 2, R7 no news)
    @(negedge clk);
    host_oe = 1'b0;
    slot = SW'(2);
    irq = last_rep_m;
    run_cycle(4, 2, 1'b0, 1'b0, "R2");
    idle_watch(6, -1, "R7");

    // New level in Quiet: Start two clocks after the input change (R7)
    @(negedge clk);
    host_oe = 1'b0;
    irq = ~irq;
    idle_watch(4, 1, "R7");
    // Agent-opened cycle, single low clock then released (R6); flip after own sample
    run_cycle(5, 2, 1'b1, 1'b1, "R6");
    // Earliest self start: second idle clock after the Stop's high clock (R3)
    idle_watch(4, 1, "R3");
    // Stop width 4 leaves Quiet in place (R8)
    run_cycle(3, 4, 1'b1, 1'b1, "R8");
    idle_watch(4, 1, "R8");
    // Stop width 3 returns to Continuous, pending change stays silent (R2, R4)
    run_cycle(2, 3, 1'b1, 1'b1, "R2");
    idle_watch(6, -1, "R4");
    // Stop width 1 leaves Continuous in place (R8)
    @(negedge clk);
    host_oe = 1'b0;
    run_cycle(4, 1, 1'b0, 1'b1, "R8");
    idle_watch(6, -1, "R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule